// File: doc/BRIEF.md
# Serial Memory Hold and Sleep Supervisor

This block sits beside the command engine of a serial-interface memory and supervises two kinds of pause. A hold pause, requested by pulling the hold pin low while the device is selected, freezes the command engine without losing its progress and releases it only when the hold pin rises at the same serial-clock level that was present when the pause began. A sleep pause is a low-power state entered when the chip select rises after a complete sleep op-code. Leaving it takes a timed recovery that starts at a chip-select falling edge.

All pins are sampled on a free-running system clock that is assumed to be much faster than the serial clock and already synchronous to it. The command engine reports that a full sleep op-code has been decoded and whether a read-type transfer is under way. In return it receives an advance gate, an override that floats the serial output, a one-cycle abort pulse and a sleep indicator. Every output derived from pin activity moves one system clock after the pin change is sampled. The recovery length is a parameter counted in system clocks.

Top module: `hsc_top`

## Requirements
- R1: A hold begins at the first system clock edge that samples the hold pin low while chip select is low and the block is awake. From the next cycle the advance gate `eng_gate_o` is 0. A low hold pin while chip select is high does not close the gate.
- R2: The serial-clock level sampled when the hold begins is stored. The hold ends only on a clock edge that samples the hold pin high and the serial clock at that stored level. Once the hold pin is high, the gate reopens on the cycle after the serial clock returns to the stored level.
- R3: While held, serial-clock toggles do not reopen the gate. Ending a hold normally produces no abort pulse.
- R4: While held, `so_hiz_o` is 1 exactly when `rd_busy_i` is 1. Outside hold and sleep, `so_hiz_o` is 0.
- R5: A chip-select rise while held gives a one-cycle `abort_o` pulse on the following cycle and releases the hold. A chip-select rise without hold gives no pulse.
- R6: When `sleep_op_i` is seen with chip select low, the block arms. The next chip-select rise then sets `sleep_o` on the following cycle, and from that cycle `eng_gate_o` is 0 and `so_hiz_o` is 1.
- R7: A rising serial-clock edge that is not held, seen between arming and the chip-select rise, cancels sleep entry. A falling edge in that window does not cancel it.
- R8: While asleep, serial-clock activity and a low hold pin leave `sleep_o` at 1, `eng_gate_o` at 0 and `so_hiz_o` at 1.
- R9: A chip-select fall while asleep starts recovery. `sleep_o` stays 1 for exactly REC_CYCLES system clocks after the edge is sampled and then drops, whether or not chip select returns high in between.
- R10: A further chip-select fall during recovery gives a one-cycle `proto_err_o` pulse and does not restart or lengthen the recovery.
- R11: After reset the block is awake and not held: `eng_gate_o`=1, and `so_hiz_o`, `abort_o`, `sleep_o` and `proto_err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock level |
| hold_ni | input | 1 | Hold request, active low |
| sleep_op_i | input | 1 | Command engine has decoded a full sleep op-code |
| rd_busy_i | input | 1 | Command engine is streaming read data |
| eng_gate_o | output | 1 | Command engine may advance |
| so_hiz_o | output | 1 | Force the serial output to high impedance |
| abort_o | output | 1 | One-cycle pulse: the frame was aborted during hold |
| sleep_o | output | 1 | Asleep or recovering |
| proto_err_o | output | 1 | One-cycle pulse: chip select fell again during recovery |

## Verification
The hardest state to reach is the recovery window with a second chip-select fall inside it. The stimulus has to arm with the sleep flag, raise chip select with no serial-clock rise in between, drop chip select to start the count, and then toggle chip select partway through. At that point the bench checks both the error pulse and that the original end cycle is kept. A related case is the sleep entry in which the serial clock falls after the op-code. It is built by idling the clock high, pulsing the flag and then lowering the clock, which shows that only rising edges cancel.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  typedef enum logic [1:0] {
    SL_AWAKE   = 2'd0,
    SL_ARMED   = 2'd1,
    SL_ASLEEP  = 2'd2,
    SL_RECOVER = 2'd3
  } sleep_st_e;
endpackage

// File: rtl/hsc_pin_edges.sv
module hsc_pin_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic sck_rise_o
);
  localparam int NPIN = 2;
  localparam logic [NPIN-1:0] RST_VAL = 2'b01; // cs idles high, sck low

  logic [NPIN-1:0] pin_now, pin_q, rise, fall;
  assign pin_now = {sck_i, cs_ni};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_q[g] <= RST_VAL[g];
      else         pin_q[g] <= pin_now[g];
    end
    assign rise[g] = pin_now[g] & ~pin_q[g];
    assign fall[g] = ~pin_now[g] & pin_q[g];
  end

  assign cs_rise_o  = rise[0];
  assign cs_fall_o  = fall[0];
  assign sck_rise_o = rise[1];

  logic unused_fall;
  assign unused_fall = fall[1];
endmodule

// File: rtl/hsc_hold_track.sv
module hsc_hold_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic cs_rise_i,
  input  logic en_i,
  output logic held_o,
  output logic abort_o
);
  logic held_q, lvl_q, abort_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q  <= 1'b0;
      lvl_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      abort_q <= held_q & cs_rise_i;
      if (cs_ni) begin
        held_q <= 1'b0;
      end else if (!held_q) begin
        if (!hold_ni && en_i) begin
          held_q <= 1'b1;
          lvl_q  <= sck_i;
        end
      end else if (hold_ni && (sck_i == lvl_q)) begin
        held_q <= 1'b0;
      end
    end
  end

  assign held_o  = held_q;
  assign abort_o = abort_q;

  AST_HOLD_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(held_q) |-> $past(!cs_ni) && $past(!hold_ni)); // R1
  AST_HOLD_EXIT_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(held_q) && $past(!cs_ni)) |-> ($past(hold_ni) && ($past(sck_i) == $past(lvl_q)))); // R2
  AST_ABORT_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> !held_q && $past(held_q)); // R5
endmodule

// File: rtl/hsc_sleep_fsm.sv
module hsc_sleep_fsm
  import hsc_pkg::*;
#(
  parameter int REC_CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic cs_rise_i,
  input  logic cs_fall_i,
  input  logic sck_rise_i,
  input  logic held_i,
  input  logic sleep_op_i,
  output logic sleep_o,
  output logic proto_err_o
);
  localparam int CW = (REC_CYCLES > 2) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

  sleep_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SL_AWAKE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        SL_AWAKE:
          if (sleep_op_i && !cs_ni && !held_i) st_q <= SL_ARMED;
        SL_ARMED:
          if (cs_rise_i)                    st_q <= held_i ? SL_AWAKE : SL_ASLEEP;
          else if (sck_rise_i && !held_i)   st_q <= SL_AWAKE;
        SL_ASLEEP:
          if (cs_fall_i) begin
            st_q  <= SL_RECOVER;
            cnt_q <= '0;
          end
        SL_RECOVER: begin
          if (cs_fall_i) err_q <= 1'b1;
          if (cnt_q == LAST) st_q <= SL_AWAKE;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SL_AWAKE;
      endcase
    end
  end

  assign sleep_o     = (st_q == SL_ASLEEP) || (st_q == SL_RECOVER);
  assign proto_err_o = err_q;

  AST_REC_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SL_RECOVER && $past(st_q) == SL_RECOVER) |-> cnt_q == $past(cnt_q) + 1'b1); // R10
  AST_SLEEP_ON_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SL_ASLEEP && $past(st_q) == SL_ARMED) |-> $past(cs_ni) && $past(!held_i)); // R6
  AST_ERR_IN_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> $past(st_q) == SL_RECOVER); // R10
endmodule

// File: rtl/hsc_top.sv
module hsc_top #(
  parameter int REC_CYCLES = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic sleep_op_i,
  input  logic rd_busy_i,
  output logic eng_gate_o,
  output logic so_hiz_o,
  output logic abort_o,
  output logic sleep_o,
  output logic proto_err_o
);
  logic cs_rise, cs_fall, sck_rise, held, asleep;

  hsc_pin_edges u_edges (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i),
    .cs_rise_o(cs_rise), .cs_fall_o(cs_fall), .sck_rise_o(sck_rise)
  );

  hsc_hold_track u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i),
    .hold_ni(hold_ni), .cs_rise_i(cs_rise), .en_i(!asleep),
    .held_o(held), .abort_o(abort_o)
  );

  hsc_sleep_fsm #(.REC_CYCLES(REC_CYCLES)) u_sleep (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .cs_rise_i(cs_rise),
    .cs_fall_i(cs_fall), .sck_rise_i(sck_rise), .held_i(held),
    .sleep_op_i(sleep_op_i), .sleep_o(asleep), .proto_err_o(proto_err_o)
  );

  assign sleep_o    = asleep;
  assign eng_gate_o = !held && !asleep;
  assign so_hiz_o   = asleep || (held && rd_busy_i);

  AST_SLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o |-> so_hiz_o && !eng_gate_o); // R8
  AST_NO_HOLD_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(asleep) && asleep |-> !held); // R8
endmodule

// File: tb/hsc_top_bench.sv
module hsc_top_bench;
  localparam int CLK_P = 10;
  localparam int REC   = 20;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, hold_ni = 1'b1, sleep_op_i = 1'b0, rd_busy_i = 1'b0;
  logic eng_gate_o, so_hiz_o, abort_o, sleep_o, proto_err_o;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hsc_top #(.REC_CYCLES(REC)) u_hsc_top (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .hold_ni(hold_ni),
    .sleep_op_i(sleep_op_i), .rd_busy_i(rd_busy_i), .eng_gate_o(eng_gate_o),
    .so_hiz_o(so_hiz_o), .abort_o(abort_o), .sleep_o(sleep_o), .proto_err_o(proto_err_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    chk("R11 gate", eng_gate_o, 1'b1);
    chk("R11 hiz", so_hiz_o, 1'b0);
    chk("R11 abort", abort_o, 1'b0);
    chk("R11 sleep", sleep_o, 1'b0);
    chk("R11 err", proto_err_o, 1'b0);
  endtask

  task automatic t_hold_sck_low;
    cs_ni = 0; sck_i = 0; tick(1);
    hold_ni = 0; tick(1);
    chk("R1 gate closed", eng_gate_o, 1'b0);
    sck_i = 1; tick(1);
    chk("R3 sck ignored", eng_gate_o, 1'b0);
    hold_ni = 1; tick(1);
    chk("R2 wrong level keeps hold", eng_gate_o, 1'b0);
    sck_i = 0; tick(1);
    chk("R2 exit at low level", eng_gate_o, 1'b1);
    chk("R3 no abort on exit", abort_o, 1'b0);
    cs_ni = 1; tick(2);
  endtask

  task automatic t_hold_sck_high;
    sck_i = 1; tick(1);
    cs_ni = 0; tick(1);
    hold_ni = 0; tick(1);
    chk("R1 gate closed high", eng_gate_o, 1'b0);
    sck_i = 0; tick(1);
    hold_ni = 1; tick(1);
    chk("R2 low level keeps high hold", eng_gate_o, 1'b0);
    sck_i = 1; tick(1);
    chk("R2 exit at high level", eng_gate_o, 1'b1);
    cs_ni = 1; sck_i = 0; tick(2);
  endtask

  task automatic t_hold_cs_high;
    hold_ni = 0; tick(2);
    chk("R1 no hold while deselected", eng_gate_o, 1'b1);
    hold_ni = 1; tick(1);
  endtask

  task automatic t_hiz;
    cs_ni = 0; tick(1);
    rd_busy_i = 1; tick(1);
    chk("R4 no hiz outside hold", so_hiz_o, 1'b0);
    rd_busy_i = 0; hold_ni = 0; tick(1);
    chk("R4 no hiz held without read", so_hiz_o, 1'b0);
    rd_busy_i = 1; tick(1);
    chk("R4 hiz held with read", so_hiz_o, 1'b1);
    hold_ni = 1; rd_busy_i = 0; tick(1);
    cs_ni = 1; tick(2);
  endtask

  task automatic t_abort;
    cs_ni = 0; tick(1);
    hold_ni = 0; tick(1);
    cs_ni = 1; tick(1);
    chk("R5 abort pulse", abort_o, 1'b1);
    chk("R5 hold released", eng_gate_o, 1'b1);
    tick(1);
    chk("R5 abort one cycle", abort_o, 1'b0);
    hold_ni = 1; tick(1);
    cs_ni = 0; tick(2);
    cs_ni = 1; tick(1);
    chk("R5 no abort without hold", abort_o, 1'b0);
    tick(1);
  endtask

  task automatic t_sleep_cancel;
    cs_ni = 0; tick(1);
    sleep_op_i = 1; tick(1);
    sleep_op_i = 0; sck_i = 1; tick(1);
    sck_i = 0; tick(1);
    cs_ni = 1; tick(1);
    chk("R7 rising edge cancels", sleep_o, 1'b0);
    tick(1);
  endtask

  task automatic wake(input string req);
    cs_ni = 0; tick(REC);
    chk({req, " still recovering"}, sleep_o, 1'b1);
    tick(1);
    chk({req, " awake"}, sleep_o, 1'b0);
    chk({req, " gate open"}, eng_gate_o, 1'b1);
    cs_ni = 1; tick(1);
  endtask

  task automatic t_sleep_falling_edge;
    sck_i = 1; tick(1);
    cs_ni = 0; tick(1);
    sleep_op_i = 1; tick(1);
    sleep_op_i = 0; sck_i = 0; tick(1);
    cs_ni = 1; tick(1);
    chk("R7 falling edge keeps entry", sleep_o, 1'b1);
    wake("R9");
  endtask

  task automatic t_sleep_main;
    sck_i = 1; cs_ni = 0; tick(1);
    sleep_op_i = 1; tick(1);
    sleep_op_i = 0; cs_ni = 1; tick(1);
    chk("R6 asleep", sleep_o, 1'b1);
    chk("R6 gate closed", eng_gate_o, 1'b0);
    chk("R6 hiz", so_hiz_o, 1'b1);
    for (int i = 0; i < 4; i++) begin
      sck_i = ~sck_i; tick(1);
    end
    hold_ni = 0; tick(2);
    chk("R8 stays asleep", sleep_o, 1'b1);
    chk("R8 gate closed", eng_gate_o, 1'b0);
    chk("R8 hiz", so_hiz_o, 1'b1);
    hold_ni = 1; sck_i = 0; tick(1);
    // recovery with chip select released partway
    cs_ni = 0; tick(3);
    cs_ni = 1; tick(REC - 3);
    chk("R9 recovery kept with cs high", sleep_o, 1'b1);
    tick(1);
    chk("R9 awake after recovery", sleep_o, 1'b0);
  endtask

  task automatic t_proto_err;
    cs_ni = 0; tick(1);
    sleep_op_i = 1; tick(1);
    sleep_op_i = 0; cs_ni = 1; tick(1);
    chk("R6 asleep again", sleep_o, 1'b1);
    cs_ni = 0; tick(5);
    cs_ni = 1; tick(1);
    chk("R10 no err on rise", proto_err_o, 1'b0);
    cs_ni = 0; tick(1);
    chk("R10 err pulse", proto_err_o, 1'b1);
    tick(1);
    chk("R10 err one cycle", proto_err_o, 1'b0);
    tick(REC - 8);
    chk("R10 not restarted, still recovering", sleep_o, 1'b1);
    tick(1);
    chk("R10 ends on original cycle", sleep_o, 1'b0);
    cs_ni = 1; tick(1);
  endtask

  initial begin
    tick(2);
    rst_ni = 1'b1;
    tick(1);
    t_reset();
    t_hold_sck_low();
    t_hold_sck_high();
    t_hold_cs_high();
    t_hiz();
    t_abort();
    t_sleep_cancel();
    t_sleep_falling_edge();
    t_sleep_main();
    t_proto_err();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule